// File: doc/BRIEF.md
# Trimmed One-Second Divider

This block turns a 32768 Hz clock-enable into a one-second tick. The enable first drives a 256-count prescaler. The prescaler output passes through a pulse corrector, and a binary post-divider then counts the corrected pulses down to 1 Hz. The corrector trims the rate in the digital domain. It can suppress one prescaler pulse, which drops 256 input counts and slows the clock. It can also add one extra pulse halfway between two normal ones, which gains 256 counts and speeds the clock up.

Corrections are scheduled over a fixed window of 32 slots, and each slot lasts SLOT_SECS seconds (120 by default, so the window is 64 minutes). The calibration input has two parts: a 5-bit magnitude N and a direction bit. These are sampled only when a new window begins. One correction event then takes place in each of the first N slots of that window, on the first prescaler pulse of the slot. The corrected prescaler pulse stream is also brought out as a frequency-test output, so the trim can be measured against a reference.

Top module: `rtc_trim_divider`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `tick_1hz` and `ftest` are low. The window that starts at reset applies no correction, whatever the calibration inputs are.
- R2: With no correction, `ftest` pulses for one cycle on every 256th accepted enable. `tick_1hz` pulses on every 2^POST_BITS-th `ftest` pulse, in the same cycle as that `ftest` pulse. Each output appears one clock after the edge that accepts the causing enable.
- R3: A magnitude of 0 gives a window of exactly 32 * SLOT_SECS * 2^POST_BITS * 256 accepted enables, whatever the sign.
- R4: With `cal_neg` = 1 and magnitude N, the first prescaler pulse in each of slots 0 to N-1 is suppressed. The window lengthens by N * 256 enables.
- R5: With `cal_neg` = 0 and magnitude N, an extra `ftest` pulse is inserted in each of slots 0 to N-1. It comes 128 enables after the first prescaler pulse of the slot. The window shortens by N * 256 enables.
- R6: The magnitude and sign are sampled in the clock after the tick that starts a window. A change in the middle of a window has no effect until the next window.
- R7: A window holds exactly 32 slots of SLOT_SECS ticks each. In every window, corrected or not, `ftest` pulses 32 * SLOT_SECS * 2^POST_BITS times.
- R8: The largest magnitude, 31, corrects 31 of the 32 slots.
- R9: Cycles with `osc_en` low advance nothing, so irregular enable spacing changes no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | 32768 Hz count enable, one cycle wide |
| cal_mag | input | MAG_W | Correction magnitude N (0 to 31) |
| cal_neg | input | 1 | 1 = remove counts (slow down), 0 = add counts (speed up) |
| tick_1hz | output | 1 | One-cycle pulse per second |
| ftest | output | 1 | One-cycle pulse per corrected prescaler output |

## Verification
The divider is run through four consecutive windows, each with a different setting:
- The reset window is entered with a nonzero negative code, which shows that no correction is applied before the first window boundary.
- A negative magnitude of 5 is loaded next. Part way through that window the inputs switch to a positive 31. This tells suppression apart from deferred loading.
- The positive-31 window follows, which covers the insertion and the full-scale case.
- The last window uses a zero magnitude with the sign set and gapped enables. This shows that the sign alone does nothing and that idle cycles are not counted.

Window lengths, measured in accepted enables between window-closing ticks, separate the three cases: +N*256, -N*256 and no change. A per-cycle model separates the timing of inserted and suppressed pulses.

// File: rtl/rtc_trim_pkg.sv
`timescale 1ns / 1ps
package rtc_trim_pkg;
    // What the corrector did with the prescaler event seen this cycle
    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_PASS  = 2'd1,
        ACT_DROP  = 2'd2,
        ACT_EXTRA = 2'd3
    } trim_act_e;
endpackage

// File: rtl/rtc_trim_prescale.sv
`timescale 1ns / 1ps
module rtc_trim_prescale #(
    parameter int PRE_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_en,
    output logic full_o,
    output logic half_o
);
    localparam logic [PRE_BITS-1:0] HALF_VAL = PRE_BITS'((1 << (PRE_BITS - 1)) - 1);
    localparam logic [PRE_BITS-1:0] FULL_VAL = '1;

    typedef struct packed {
        logic [PRE_BITS-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        full_o = osc_en && (st_q.cnt == FULL_VAL);
        half_o = osc_en && (st_q.cnt == HALF_VAL);
        if (osc_en) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |=> $stable(st_q.cnt));
    // R9
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        osc_en |=> (st_q.cnt == PRE_BITS'($past(st_q.cnt) + 1'b1)));
endmodule

// File: rtl/rtc_trim_corrector.sv
`timescale 1ns / 1ps
module rtc_trim_corrector
    import rtc_trim_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic full_i,
    input  logic half_i,
    input  logic arm_i,
    input  logic neg_i,
    output logic pulse_o
);
    typedef struct packed {
        logic pend;
        logic extra;
    } corr_state_t;

    corr_state_t st_d, st_q;
    trim_act_e   act;

    always_comb begin
        st_d = st_q;
        act  = ACT_IDLE;
        if (full_i) begin
            if (st_q.pend && neg_i) begin
                act       = ACT_DROP;
                st_d.pend = 1'b0;
            end else begin
                act = ACT_PASS;
                if (st_q.pend) begin
                    st_d.pend  = 1'b0;
                    st_d.extra = 1'b1;
                end
            end
        end else if (half_i && st_q.extra) begin
            act        = ACT_EXTRA;
            st_d.extra = 1'b0;
        end
        if (arm_i) begin
            st_d.pend = 1'b1;
        end
        pulse_o = (act == ACT_PASS) || (act == ACT_EXTRA);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4
    drop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && full_i && neg_i) |-> !pulse_o);
    // R5
    split_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && full_i && !neg_i && !arm_i) |=> (st_q.extra && !st_q.pend));
endmodule

// File: rtl/rtc_trim_postdiv.sv
`timescale 1ns / 1ps
module rtc_trim_postdiv #(
    parameter int POST_BITS = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_i,
    output logic tick_o,
    output logic ftest_o
);
    localparam logic [POST_BITS-1:0] LAST_VAL = '1;

    typedef struct packed {
        logic [POST_BITS-1:0] cnt;
        logic                 tick;
        logic                 ftest;
    } post_state_t;

    post_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.ftest = pulse_i;
        st_d.tick  = pulse_i && (st_q.cnt == LAST_VAL);
        if (pulse_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o  = st_q.tick;
    assign ftest_o = st_q.ftest;

    // R2
    tick_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> ftest_o);
    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_i |=> ($stable(st_q.cnt) && !ftest_o));
endmodule

// File: rtl/rtc_trim_window.sv
`timescale 1ns / 1ps
module rtc_trim_window #(
    parameter int MAG_W     = 5,
    parameter int SLOT_SECS = 120
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [MAG_W-1:0] cal_mag_i,
    input  logic             cal_neg_i,
    output logic             arm_o,
    output logic             neg_o
);
    localparam int                SEC_W    = (SLOT_SECS > 1) ? $clog2(SLOT_SECS) : 1;
    localparam logic [SEC_W-1:0]  SEC_LAST = SEC_W'(SLOT_SECS - 1);
    localparam logic [MAG_W-1:0]  SLOT_LAST = '1;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [MAG_W-1:0] slot;
        logic [MAG_W-1:0] mag;
        logic             neg;
    } win_state_t;

    win_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        arm_o = 1'b0;
        if (tick_i) begin
            if (st_q.sec == SEC_LAST) begin
                st_d.sec  = '0;
                st_d.slot = st_q.slot + 1'b1;
                if (st_q.slot == SLOT_LAST) begin
                    st_d.mag = cal_mag_i;
                    st_d.neg = cal_neg_i;
                end
                arm_o = (st_d.slot < st_d.mag);
            end else begin
                st_d.sec = st_q.sec + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign neg_o = st_q.neg;

    // R7
    slot_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(st_q.slot));
    // R6
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.slot != '0) |-> ($stable(st_q.mag) && $stable(st_q.neg)));
    // R8
    arm_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_o |=> (st_q.slot < st_q.mag));
endmodule

// File: rtl/rtc_trim_divider.sv
`timescale 1ns / 1ps
module rtc_trim_divider #(
    parameter int PRE_BITS  = 8,
    parameter int POST_BITS = 7,
    parameter int MAG_W     = 5,
    parameter int SLOT_SECS = 120
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_en,
    input  logic [MAG_W-1:0] cal_mag,
    input  logic             cal_neg,
    output logic             tick_1hz,
    output logic             ftest
);
    logic full_w;
    logic half_w;
    logic arm_w;
    logic neg_w;
    logic pulse_w;

    rtc_trim_prescale #(.PRE_BITS(PRE_BITS)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .osc_en (osc_en),
        .full_o (full_w),
        .half_o (half_w)
    );

    rtc_trim_corrector u_corr (
        .clk     (clk),
        .rst_n   (rst_n),
        .full_i  (full_w),
        .half_i  (half_w),
        .arm_i   (arm_w),
        .neg_i   (neg_w),
        .pulse_o (pulse_w)
    );

    rtc_trim_postdiv #(.POST_BITS(POST_BITS)) u_post (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_i (pulse_w),
        .tick_o  (tick_1hz),
        .ftest_o (ftest)
    );

    rtc_trim_window #(.MAG_W(MAG_W), .SLOT_SECS(SLOT_SECS)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_1hz),
        .cal_mag_i (cal_mag),
        .cal_neg_i (cal_neg),
        .arm_o     (arm_w),
        .neg_o     (neg_w)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!tick_1hz && !ftest));
endmodule

// File: tb/rtc_trim_divider_test.sv
`timescale 1ns / 1ps
module rtc_trim_divider_test;
    localparam int POST_BITS = 2;
    localparam int SLOT_SECS = 1;
    localparam int POST_N    = 1 << POST_BITS;
    localparam int WIN_OSC   = 32 * SLOT_SECS * POST_N * 256;
    localparam int WIN_TICKS = 32 * SLOT_SECS;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       osc_en;
    logic [4:0] cal_mag;
    logic       cal_neg;
    logic       tick_1hz;
    logic       ftest;

    always #2.5 clk = ~clk;

    rtc_trim_divider #(.PRE_BITS(8), .POST_BITS(POST_BITS), .MAG_W(5), .SLOT_SECS(SLOT_SECS)) uut (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .cal_mag(cal_mag),
        .cal_neg(cal_neg), .tick_1hz(tick_1hz), .ftest(ftest)
    );

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    int m_phase = 0, m_cnt = 0, m_sec = 0, m_slot = 0, m_mag = 0;
    bit m_neg = 0, m_pend = 0, m_split = 0, m_tick = 0, m_ft = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_step(input bit en);
        bit arm = 0;
        bit cp  = 0;
        if (m_tick) begin
            m_sec++;
            if (m_sec == SLOT_SECS) begin
                m_sec  = 0;
                m_slot = (m_slot + 1) % 32;
                if (m_slot == 0) begin
                    m_mag = int'(cal_mag);
                    m_neg = cal_neg;
                end
                arm = (m_slot < m_mag);
            end
        end
        if (en) begin
            if (m_phase == 255) begin
                if (m_pend && m_neg) m_pend = 0;
                else begin
                    cp = 1;
                    if (m_pend) begin m_pend = 0; m_split = 1; end
                end
            end else if (m_phase == 127 && m_split) begin
                cp = 1;
                m_split = 0;
            end
            m_phase = (m_phase + 1) % 256;
        end
        if (arm) m_pend = 1;
        m_tick = cp && (m_cnt == POST_N - 1);
        if (cp) m_cnt = (m_cnt + 1) % POST_N;
        m_ft = cp;
    endtask

    initial begin
        int  osc_total = 0;
        int  ticks = 0;
        int  cyc = 0;
        int  ft_win = 0;
        int  osc_at[5];
        int  ft_at[5];
        bit  applied = 0;
        bit  hung = 0;
        osc_at[0] = 0;
        ft_at[0]  = 0;
        rst_n   = 1'b0;
        osc_en  = 1'b0;
        cal_mag = 5'd5;
        cal_neg = 1'b1;
        repeat (4) @(negedge clk);
        // R1: quiet outputs in reset
        check(tick_1hz == 1'b0, "R1 tick in reset", int'(tick_1hz), 0);
        check(ftest == 1'b0, "R1 ftest in reset", int'(ftest), 0);
        rst_n   = 1'b1;
        osc_en  = 1'b1;
        applied = 1'b1;
        while (ticks < 4 * WIN_TICKS) begin
            @(negedge clk);
            cyc++;
            if (cyc > 190000) begin
                hung = 1;
                break;
            end
            if (applied) osc_total++;
            model_step(applied);
            // R2 R4 R5 R6 cycle-level comparison against reference
            check(tick_1hz == m_tick, "R2/R4/R5/R6 tick vs model", int'(tick_1hz), int'(m_tick));
            check(ftest == m_ft, "R2/R4/R5/R6 ftest vs model", int'(ftest), int'(m_ft));
            if (ftest) ft_win++;
            if (ftest && ticks < WIN_TICKS)
                // R2: uncorrected pulses land on multiples of 256
                check(osc_total % 256 == 0, "R2 ftest spacing", osc_total % 256, 0);
            if (tick_1hz) begin
                ticks++;
                if (ticks <= WIN_TICKS)
                    // R2: uncorrected ticks every 256*2^POST_BITS enables
                    check(osc_total == ticks * POST_N * 256, "R2 tick spacing", osc_total, ticks * POST_N * 256);
                if (ticks % WIN_TICKS == 0) begin
                    osc_at[ticks / WIN_TICKS] = osc_total;
                    ft_at[ticks / WIN_TICKS]  = ft_win;
                end
            end
            // schedule of calibration changes (mid-window, R6)
            if (ticks == WIN_TICKS + WIN_TICKS / 2) begin
                cal_mag = 5'd31;
                cal_neg = 1'b0;
            end
            if (ticks == 2 * WIN_TICKS + WIN_TICKS / 2) begin
                cal_mag = 5'd0;
                cal_neg = 1'b1;
            end
            // R9: gapped enables during the last window
            if (ticks >= 3 * WIN_TICKS && ticks < 3 * WIN_TICKS + 8)
                applied = (cyc % 3 == 0);
            else
                applied = 1'b1;
            osc_en = applied;
        end
        if (hung) begin
            check(1'b0, "watchdog expired", cyc, 190000);
        end else begin
            // R1 R7: reset window uncorrected despite nonzero code
            check(osc_at[1] - osc_at[0] == WIN_OSC, "R1 reset window length",
                  osc_at[1] - osc_at[0], WIN_OSC);
            // R4 R6: negative 5, changed mid-window without effect
            check(osc_at[2] - osc_at[1] == WIN_OSC + 5 * 256, "R4/R6 negative window length",
                  osc_at[2] - osc_at[1], WIN_OSC + 5 * 256);
            // R5 R8: positive 31
            check(osc_at[3] - osc_at[2] == WIN_OSC - 31 * 256, "R5/R8 positive full-scale window length",
                  osc_at[3] - osc_at[2], WIN_OSC - 31 * 256);
            // R3 R9: zero magnitude, sign set, gapped enables
            check(osc_at[4] - osc_at[3] == WIN_OSC, "R3/R9 zero-magnitude window length",
                  osc_at[4] - osc_at[3], WIN_OSC);
            for (int w = 1; w <= 4; w++)
                // R7: pulses per window fixed
                check(ft_at[w] - ft_at[w - 1] == 32 * SLOT_SECS * POST_N, "R7 ftest per window",
                      ft_at[w] - ft_at[w - 1], 32 * SLOT_SECS * POST_N);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule